// File: doc/BRIEF.md
# Dual-Half Timer/Counter with Capture

This block is a 16-bit timer/counter made of two 8-bit halves, low and high. Each half keeps its own running count, its own match value and its own capture register. A shared programmable prescaler divides the system clock into count enables for the timer modes. A single external event pin can drive the halves instead, as an event counter. A 2-bit mode input sets the combination. The halves run split, as two 8-bit units, or cascaded, as one 16-bit unit in which the high half steps each time the low half wraps.

Each half has its own capture pin. The event pin and both capture pins pass through a two-flop synchroniser and a rising-edge detector inside the block. A capture stores the count that is present in the cycle in which the edge is detected. In the cascaded modes a capture stores all 16 bits at once. Each half has a sticky flag that is driven out as its own interrupt request. The prescaler's enable pulse is also driven out, so that another timer can use it as a clock source.

Configuration arrives through a simple write port. Address 0 holds the prescaler value, address 1 the low match value and address 2 the high match value. The counts and the captured values are visible on output ports.

Top module: `mtc_top`

## Requirements
- R1: After reset (rst_n low), cnt_lo, cnt_hi, cap_lo, cap_hi, irq_lo, irq_hi and presc_tick are all 0, and the prescaler and both match values are 0.
- R2: A write with wr_addr=0 sets the prescaler value N. While run is 1, presc_tick is high for one cycle in every N+1 clocks. While run is 0, presc_tick is 0 and the prescaler count restarts from 0.
- R3: With mode=2'b00, each half advances on every presc_tick. It counts from 0 up to its match value, returns to 0 on the next enable after reaching the match, and on that enable sets its own flag (irq_lo or irq_hi).
- R4: With mode=2'b01, the low half advances on presc_tick. The high half advances on each rising edge of evt_in, and that edge shows in cnt_hi after the third rising clock edge that follows the pin change. Each half reloads and flags as in R3.
- R5: With mode=2'b10, the low half advances on presc_tick and the high half advances only on an enable in which the low half wraps. irq_hi is set when both halves are at their match values on an enable. irq_lo is never set.
- R6: With mode=2'b11, the halves behave as in R5, but the low half is enabled by synchronised rising edges of evt_in instead of presc_tick.
- R7: In modes 2'b00 and 2'b01, a synchronised rising edge on cap_lo_in copies cnt_lo into cap_lo, and one on cap_hi_in copies cnt_hi into cap_hi. The copied value is the count present in the cycle in which the edge is detected.
- R8: In modes 2'b10 and 2'b11, a rising edge on either capture pin copies both halves into cap_lo and cap_hi in the same cycle.
- R9: A write to a match register (wr_addr=1 low, wr_addr=2 high) while run is 0 also sets that half's count to 0. The same write while run is 1 leaves the count unchanged.
- R10: flag_clr[0] clears irq_lo and flag_clr[1] clears irq_hi. A flag set in the same cycle wins over the clear.
- R11: While run is 0, neither count changes on prescaler or evt_in activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counting enable for the prescaler and both halves |
| mode | input | 2 | 00 split timers, 01 timer + event counter, 10 cascaded timer, 11 cascaded event counter |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | 0 prescaler, 1 low match, 2 high match, 3 no effect |
| wr_data | input | 8 | Write data |
| flag_clr | input | 2 | Bit 0 clears irq_lo, bit 1 clears irq_hi |
| evt_in | input | 1 | Asynchronous external event pin |
| cap_lo_in | input | 1 | Asynchronous low-half capture pin |
| cap_hi_in | input | 1 | Asynchronous high-half capture pin |
| presc_tick | output | 1 | Prescaler enable pulse, also usable as a clock source by another timer |
| cnt_lo | output | 8 | Low half count |
| cnt_hi | output | 8 | High half count |
| cap_lo | output | 8 | Low half capture value |
| cap_hi | output | 8 | High half capture value |
| irq_lo | output | 1 | Low half flag / interrupt request |
| irq_hi | output | 1 | High half flag / interrupt request |

## Verification
Every piece of state in this block reaches a port within a cycle. A wrong count, a missing reload or a missed cascade step shows up on cnt_lo or cnt_hi at the first clock edge after the fault. A prescaler that is off by one shows up as a presc_tick pulse that arrives one cycle early or late. A fault in the synchroniser shifts by one cycle the count step or capture that follows an edge on a pin. A wrong flag rule shows up on irq_lo or irq_hi in the enable cycle where it happens. For this reason the bench compares a behavioural model against all outputs on every clock, so it finds any departure in the cycle it occurs.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
    typedef enum logic [1:0] {
        MODE_SPLIT_TT = 2'b00,
        MODE_SPLIT_TE = 2'b01,
        MODE_CASC_T   = 2'b10,
        MODE_CASC_E   = 2'b11
    } mtc_mode_e;

    localparam logic [1:0] ADDR_PRESC = 2'd0;
    localparam logic [1:0] ADDR_MLO   = 2'd1;
    localparam logic [1:0] ADDR_MHI   = 2'd2;

    typedef struct packed {
        logic flag_lo;
        logic flag_hi;
    } mtc_flags_t;
endpackage

// File: rtl/mtc_edge_sync.sv
module mtc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    localparam int SW = STAGES + 1;

    logic [SW-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SW-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[SW-2] & ~sh_q[SW-1];

    // R4: a detected edge lasts a single cycle
    assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/mtc_prescaler.sv
module mtc_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         tick
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] div;
        logic [W-1:0] cnt;
    } ps_state_t;

    ps_state_t st_d, st_q;

    assign tick = run && (st_q.cnt == st_q.div);

    always_comb begin
        st_d = st_q;
        if (!run)      st_d.cnt = '0;
        else if (tick) st_d.cnt = '0;
        else           st_d.cnt = st_q.cnt + ONE;
        if (load)      st_d.div = load_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: with a divider above zero, two pulses never come back to back
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.div != '0 && !load) |=> !tick);
    // R2: no pulse while stopped
    assert_tick_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);
endmodule

// File: rtl/mtc_half.sv
module mtc_half #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         match_wr,
    input  logic         clr_cnt,
    input  logic [W-1:0] wdata,
    input  logic         cap_stb,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cap,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] match;
        logic [W-1:0] cnt;
        logic [W-1:0] cap;
    } half_state_t;

    half_state_t st_d, st_q;

    assign wrap = (st_q.cnt == st_q.match);
    assign cnt  = st_q.cnt;
    assign cap  = st_q.cap;

    always_comb begin
        st_d = st_q;
        if (en)       st_d.cnt   = wrap ? '0 : st_q.cnt + ONE;
        if (match_wr) st_d.match = wdata;
        if (clr_cnt)  st_d.cnt   = '0;
        if (cap_stb)  st_d.cap   = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wrap && !clr_cnt) |=> (cnt == '0));
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wrap && !clr_cnt) |=> (cnt == $past(cnt) + ONE));
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr_cnt) |=> $stable(cnt));
    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> (cap == $past(cnt)));
endmodule

// File: rtl/mtc_top.sv
module mtc_top
    import mtc_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [1:0]   mode,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   flag_clr,
    input  logic         evt_in,
    input  logic         cap_lo_in,
    input  logic         cap_hi_in,
    output logic         presc_tick,
    output logic [W-1:0] cnt_lo,
    output logic [W-1:0] cnt_hi,
    output logic [W-1:0] cap_lo,
    output logic [W-1:0] cap_hi,
    output logic         irq_lo,
    output logic         irq_hi
);
    localparam int NPIN  = 3;
    localparam int NHALF = 2;

    logic [NPIN-1:0]  pin_vec, rise_vec;
    logic             ev_en, cap_ev_lo, cap_ev_hi, casc;
    logic [NHALF-1:0] en_v, mwr_v, clr_v, stb_v, wrap_v;
    logic [W-1:0]     cnt_v [NHALF];
    logic [W-1:0]     cap_v [NHALF];
    mtc_mode_e        mode_e;
    mtc_flags_t       fl_d, fl_q;

    assign pin_vec   = {cap_hi_in, cap_lo_in, evt_in};
    assign ev_en     = rise_vec[0] & run;
    assign cap_ev_lo = rise_vec[1];
    assign cap_ev_hi = rise_vec[2];
    assign mode_e    = mtc_mode_e'(mode);
    assign casc      = mode[1];

    for (genvar gi = 0; gi < NPIN; gi++) begin : g_sync
        mtc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst_n (rst_n),
            .pin (pin_vec[gi]),
            .rise (rise_vec[gi])
        );
    end

    mtc_prescaler #(.W(W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .load     (wr_en && wr_addr == ADDR_PRESC),
        .load_val (wr_data),
        .tick     (presc_tick)
    );

    always_comb begin
        unique case (mode_e)
            MODE_SPLIT_TT: en_v = {presc_tick, presc_tick};
            MODE_SPLIT_TE: en_v = {ev_en, presc_tick};
            MODE_CASC_T:   en_v = {presc_tick & wrap_v[0], presc_tick};
            MODE_CASC_E:   en_v = {ev_en & wrap_v[0], ev_en};
            default:       en_v = '0;
        endcase
        mwr_v = {wr_en && wr_addr == ADDR_MHI, wr_en && wr_addr == ADDR_MLO};
        clr_v = mwr_v & {NHALF{~run}};
        stb_v = casc ? {NHALF{cap_ev_lo | cap_ev_hi}} : {cap_ev_hi, cap_ev_lo};
    end

    for (genvar gh = 0; gh < NHALF; gh++) begin : g_half
        mtc_half #(.W(W)) u_half (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en_v[gh]),
            .match_wr (mwr_v[gh]),
            .clr_cnt  (clr_v[gh]),
            .wdata    (wr_data),
            .cap_stb  (stb_v[gh]),
            .cnt      (cnt_v[gh]),
            .cap      (cap_v[gh]),
            .wrap     (wrap_v[gh])
        );
    end

    always_comb begin
        fl_d = fl_q;
        if (flag_clr[0]) fl_d.flag_lo = 1'b0;
        if (flag_clr[1]) fl_d.flag_hi = 1'b0;
        if (!casc && en_v[0] && wrap_v[0]) fl_d.flag_lo = 1'b1;
        if (en_v[1] && wrap_v[1])          fl_d.flag_hi = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign cnt_lo = cnt_v[0];
    assign cnt_hi = cnt_v[1];
    assign cap_lo = cap_v[0];
    assign cap_hi = cap_v[1];
    assign irq_lo = fl_q.flag_lo;
    assign irq_hi = fl_q.flag_hi;

    // R5: cascaded modes never raise the low flag
    assert_casc_no_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (casc && !irq_lo) |=> !irq_lo);
    // R9: match write while stopped zeroes the low count
    assert_wr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && wr_en && wr_addr == ADDR_MLO) |=> (cnt_lo == '0));
    // R10: a clear with no wrap on that enable drops the high flag
    assert_flag_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr[1] && !(en_v[1] && wrap_v[1])) |=> !irq_hi);
    // R8: cascaded capture stores both halves together
    assert_casc_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (casc && (cap_ev_lo || cap_ev_hi)) |=> (cap_lo == $past(cnt_lo) && cap_hi == $past(cnt_hi)));
endmodule

// File: tb/mtc_top_tb.sv
`timescale 1ns/1ps
module mtc_top_tb;
    logic       clk = 0, rst_n = 0, run = 0;
    logic [1:0] mode = 0, wr_addr = 0, flag_clr = 0;
    logic       wr_en = 0, evt_in = 0, cap_lo_in = 0, cap_hi_in = 0;
    logic [7:0] wr_data = 0;
    logic       presc_tick, irq_lo, irq_hi;
    logic [7:0] cnt_lo, cnt_hi, cap_lo, cap_hi;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    int m_pc, m_div, m_mlo, m_mhi, m_clo, m_chi, m_caplo, m_caphi;
    bit m_flo, m_fhi;
    bit [2:0] s_ev, s_cl, s_ch;

    always #5 clk = ~clk;

    mtc_top u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .flag_clr(flag_clr), .evt_in(evt_in),
        .cap_lo_in(cap_lo_in), .cap_hi_in(cap_hi_in), .presc_tick(presc_tick),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cap_lo(cap_lo), .cap_hi(cap_hi),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    function automatic bit m_tick();
        return run && (m_pc == m_div);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pc = 0; m_div = 0; m_mlo = 0; m_mhi = 0; m_clo = 0; m_chi = 0;
            m_caplo = 0; m_caphi = 0; m_flo = 0; m_fhi = 0;
            s_ev = 0; s_cl = 0; s_ch = 0;
        end else begin
            automatic bit tk = m_tick();
            automatic bit ev = s_ev[1] && !s_ev[2] && run;
            automatic bit cl = s_cl[1] && !s_cl[2];
            automatic bit ch = s_ch[1] && !s_ch[2];
            automatic bit casc = mode[1];
            automatic bit lo_en = (mode == 2'b11) ? ev : tk;
            automatic bit lo_w = (m_clo == m_mlo);
            automatic bit hi_w = (m_chi == m_mhi);
            automatic bit hi_en;
            automatic int nlo = m_clo, nhi = m_chi;
            case (mode)
                2'b00: hi_en = tk;
                2'b01: hi_en = ev;
                default: hi_en = lo_en && lo_w;
            endcase
            if (lo_en) nlo = lo_w ? 0 : m_clo + 1;
            if (hi_en) nhi = hi_w ? 0 : m_chi + 1;
            if (casc ? (cl || ch) : cl) m_caplo = m_clo;
            if (casc ? (cl || ch) : ch) m_caphi = m_chi;
            if (flag_clr[0]) m_flo = 0;
            if (flag_clr[1]) m_fhi = 0;
            if (!casc && lo_en && lo_w) m_flo = 1;
            if (hi_en && hi_w) m_fhi = 1;
            m_pc = !run ? 0 : (tk ? 0 : m_pc + 1);
            if (wr_en && wr_addr == 2'd0) m_div = wr_data;
            if (wr_en && wr_addr == 2'd1) begin m_mlo = wr_data; if (!run) nlo = 0; end
            if (wr_en && wr_addr == 2'd2) begin m_mhi = wr_data; if (!run) nhi = 0; end
            m_clo = nlo; m_chi = nhi;
            s_ev = {s_ev[1:0], evt_in};
            s_cl = {s_cl[1:0], cap_lo_in};
            s_ch = {s_ch[1:0], cap_hi_in};
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "presc_tick", presc_tick, m_tick());
            chk(cur_req, "cnt_lo", cnt_lo, m_clo);
            chk(cur_req, "cnt_hi", cnt_hi, m_chi);
            chk(cur_req, "cap_lo", cap_lo, m_caplo);
            chk(cur_req, "cap_hi", cap_hi, m_caphi);
            chk(cur_req, "irq_lo", irq_lo, m_flo);
            chk(cur_req, "irq_hi", irq_hi, m_fhi);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            finish_run();
        end
    end

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 0;
    endtask

    task automatic clr_flags();
        flag_clr = 2'b11; step(1); flag_clr = 2'b00;
    endtask

    task automatic pulse_evt();
        evt_in = 1; step(3); evt_in = 0; step(3);
    endtask

    initial begin
        int ticks;
        step(3);
        // R1: reset state
        chk("R1", "cnt_lo", cnt_lo, 0);
        chk("R1", "cnt_hi", cnt_hi, 0);
        chk("R1", "cap_lo", cap_lo, 0);
        chk("R1", "irq_hi", irq_hi, 0);
        chk("R1", "presc_tick", presc_tick, 0);
        rst_n = 1;
        step(2);

        // R2: divider of 2 gives one pulse every 3 clocks
        cur_req = "R2";
        wr(2'd0, 8'd2);
        wr(2'd1, 8'd200); wr(2'd2, 8'd200);
        run = 1; ticks = 0;
        for (int i = 0; i < 30; i++) begin
            step(1);
            if (presc_tick) ticks++;
        end
        chk("R2", "tick count", ticks, 10);
        run = 0; step(1);
        chk("R2", "tick stopped", presc_tick, 0);

        // R3: split timers, every clock enabled
        cur_req = "R3";
        mode = 2'b00;
        wr(2'd0, 8'd0); wr(2'd1, 8'd3); wr(2'd2, 8'd5);
        clr_flags();
        run = 1; step(10); run = 0;
        chk("R3", "cnt_lo", cnt_lo, 2);
        chk("R3", "cnt_hi", cnt_hi, 4);
        chk("R3", "irq_lo", irq_lo, 1);
        chk("R3", "irq_hi", irq_hi, 1);

        // R10: clear flags
        cur_req = "R10";
        clr_flags();
        chk("R10", "irq_lo", irq_lo, 0);
        chk("R10", "irq_hi", irq_hi, 0);

        // R11: stopped, events ignored
        cur_req = "R11";
        mode = 2'b01;
        pulse_evt(); pulse_evt();
        chk("R11", "cnt_hi", cnt_hi, 4);
        chk("R11", "cnt_lo", cnt_lo, 2);

        // R4: timer low + event counter high
        cur_req = "R4";
        wr(2'd0, 8'd255); wr(2'd1, 8'd3); wr(2'd2, 8'd5);
        run = 1;
        pulse_evt(); pulse_evt(); pulse_evt();
        chk("R4", "cnt_hi", cnt_hi, 3);
        chk("R4", "cnt_lo", cnt_lo, 0);

        // R7: split capture
        cur_req = "R7";
        cap_hi_in = 1; step(3); cap_hi_in = 0; step(2);
        chk("R7", "cap_hi", cap_hi, 3);
        chk("R7", "cap_lo", cap_lo, 0);
        run = 0; step(1);

        // R5: cascaded timer
        cur_req = "R5";
        mode = 2'b10;
        wr(2'd0, 8'd0); wr(2'd1, 8'd3); wr(2'd2, 8'd2);
        clr_flags();
        run = 1; step(11);
        chk("R5", "cnt_lo", cnt_lo, 3);
        chk("R5", "cnt_hi", cnt_hi, 2);
        chk("R5", "irq_hi", irq_hi, 0);
        step(1);
        chk("R5", "cnt_lo wrap", cnt_lo, 0);
        chk("R5", "cnt_hi wrap", cnt_hi, 0);
        chk("R5", "irq_hi", irq_hi, 1);
        chk("R5", "irq_lo", irq_lo, 0);

        // R8: cascaded capture of both halves
        cur_req = "R8";
        step(5); run = 0;
        cap_lo_in = 1; step(3); cap_lo_in = 0; step(2);
        chk("R8", "cap_lo", cap_lo, 1);
        chk("R8", "cap_hi", cap_hi, 1);

        // R6: cascaded event counter
        cur_req = "R6";
        mode = 2'b11;
        wr(2'd1, 8'd1); wr(2'd2, 8'd1);
        clr_flags();
        run = 1;
        pulse_evt(); pulse_evt(); pulse_evt(); pulse_evt();
        chk("R6", "cnt_hi", cnt_hi, 0);
        chk("R6", "irq_hi", irq_hi, 1);
        chk("R6", "irq_lo", irq_lo, 0);
        pulse_evt();
        chk("R6", "cnt_lo", cnt_lo, 1);

        // R9: match write while running keeps count, while stopped clears it
        cur_req = "R9";
        wr(2'd1, 8'd7);
        chk("R9", "cnt_lo running", cnt_lo, 1);
        run = 0; step(1);
        wr(2'd1, 8'd9);
        chk("R9", "cnt_lo stopped", cnt_lo, 0);
        step(3);
        finish_run();
    end
endmodule